// File: doc/BRIEF.md
# Supply Reset Sequencer

This block turns two digitized supply-monitor flags into a core reset and a set of register-initialisation strobes. One flag, `por_ok_i`, is high while the supply is above the power-on threshold. The other, `bor_ok_i`, is high while it is above the brownout threshold. The block tells a full power-on recovery apart from a brownout-only recovery. After a power-on, it waits a power-up delay before it releases the core. After a brownout that never reached the power-on level, it releases the core at once.

When the core is released, the block issues a one-cycle load pulse for the fixed reset vector. It also issues one strobe that tells the register banks which default set to load: the power-on defaults or the brownout defaults.

The block holds a small supply-threshold field that the core may write. A brownout leaves this field unchanged. Only a power-on event clears it.

`por_ok_i` low is the block's own clear. Every flop, the threshold field included, returns to its power-on value while `por_ok_i` is low. `bor_ok_i` passes through a `SYNC_STAGES` flop synchronizer before use. `por_ok_i` also passes through a synchronizer, which clears at once when the flag drops and sets after `SYNC_STAGES` clock edges when it rises.

Top module: `supply_rst_seq`

## Requirements
- R1: `core_rst_n_o` (active low) drops with no clock edge as soon as `por_ok_i` falls. After `bor_ok_i` falls, it stays high for one more edge and is low after the second edge (SYNC_STAGES = 2). It stays low while either synchronized flag is low.
- R2: After a power-on, `core_rst_n_o` rises on the (DELAY_CYCLES + 2)th rising edge counted from the edge on which both flags are first seen high. This is two synchronizer edges plus DELAY_CYCLES edges of delay.
- R3: After a brownout-only event, `core_rst_n_o` rises on the third rising edge after `bor_ok_i` returns high. No power-up delay is applied.
- R4: `load_vec_o` is high for exactly one cycle: the first cycle in which `core_rst_n_o` is high. `pc_vec_o` always carries the reset vector 16'h8000.
- R5: Together with `load_vec_o`, exactly one of two strobes is high. `init_por_o` is high when the release follows a power-on. `init_bor_o` is high when the release follows a brownout only. The two strobes are never high together.
- R6: `init_class_o` reads 2'b01 (power-on defaults) after any power-on. It reads 2'b10 (brownout defaults) from the first brownout that follows a run phase until the next power-on.
- R7: The threshold field `thr_o` reads 2'b00 after power-on. A write with `thr_we_i` high takes effect on the next edge only while `core_rst_n_o` is high. A write is ignored while the core is held in reset.
- R8: `thr_o` keeps its value through a brownout that stays above the power-on level. It returns to 2'b00 at once when `por_ok_i` falls.
- R9: If either flag drops during the power-up delay, the delay restarts from zero. The release that follows is still a power-on release with `init_por_o`.
- R10: While `por_ok_i` is low, `bor_ok_i` high has no effect, and `core_rst_n_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_ok_i | input | 1 | Supply above power-on level; low clears the block |
| bor_ok_i | input | 1 | Supply above brownout level |
| thr_we_i | input | 1 | Threshold field write enable |
| thr_wd_i | input | THR_W | Threshold field write data |
| core_rst_n_o | output | 1 | Core reset, active low |
| load_vec_o | output | 1 | One-cycle load pulse for the reset vector |
| pc_vec_o | output | VEC_W | Reset vector value |
| init_por_o | output | 1 | Strobe: load power-on defaults |
| init_bor_o | output | 1 | Strobe: load brownout defaults |
| init_class_o | output | 2 | Class of the latest reset, 01 power-on, 10 brownout |
| thr_o | output | THR_W | Retained threshold field |

## Verification
The assertions take it as given that `por_ok_i` is a clean clear. They are disabled while it is low, so nothing is checked across an asynchronous clear. They also assume that inputs change away from the clock edge, so each synchronizer sees one settled value per edge. The bench drives every input change on the falling clock edge, and it holds every low pulse of `por_ok_i` across at least one rising edge. Brownout dips, staggered flag rises and dips in the middle of the delay are all swept within those limits.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

  typedef enum logic [0:0] {
    SEQ_HOLD = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef enum logic [1:0] {
    CLASS_NONE = 2'b00,
    CLASS_POR  = 2'b01,
    CLASS_BOR  = 2'b10
  } rst_class_e;

  // counter width able to hold span-1
  function automatic int unsigned cnt_width(input int unsigned span);
    return (span <= 2) ? 1 : $clog2(span);
  endfunction

  // the delay is over when the count has reached span-1
  function automatic logic span_done(input logic [31:0] cnt, input int unsigned span);
    return cnt == 32'(span - 1);
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer
  import supply_rst_pkg::*;
#(
  parameter int unsigned SPAN = 65536
) (
  input  logic clk,
  input  logic clr_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = cnt_width(SPAN);

  logic [CW-1:0] cnt;

  assign done = run && span_done(32'(cnt), SPAN);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)             cnt <= '0;
    else if (!run || done)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/keep_reg.sv
module keep_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)  q <= '0;
    else if (we) q <= wd;
  end
endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq
  import supply_rst_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 65536,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned THR_W        = 2,
  parameter int unsigned VEC_W        = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = 'h8000
) (
  input  logic             clk,
  input  logic             por_ok_i,
  input  logic             bor_ok_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_wd_i,
  output logic             core_rst_n_o,
  output logic             load_vec_o,
  output logic [VEC_W-1:0] pc_vec_o,
  output logic             init_por_o,
  output logic             init_bor_o,
  output logic [1:0]       init_class_o,
  output logic [THR_W-1:0] thr_o
);
  // synchronized flags; power-on low clears both chains
  logic por_s, bor_s;

  flag_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .clr_n(por_ok_i), .d(1'b1), .q(por_s)
  );
  flag_sync #(.STAGES(SYNC_STAGES)) u_bor_sync (
    .clk(clk), .clr_n(por_ok_i), .d(bor_ok_i), .q(bor_s)
  );

  seq_state_e state_q;
  rst_class_e class_q;
  logic       cold_q;
  logic       por_stb_q, bor_stb_q;

  // named internal events
  logic supply_ok, in_hold, timer_run, timer_done;
  logic release_evt, bor_entry_evt, thr_write;

  assign supply_ok     = por_s & bor_s;
  assign in_hold       = (state_q == SEQ_HOLD);
  assign timer_run     = in_hold & cold_q & supply_ok;
  assign release_evt   = in_hold & supply_ok & (!cold_q | timer_done);
  assign bor_entry_evt = (state_q == SEQ_RUN) & !supply_ok;

  pwrup_timer #(.SPAN(DELAY_CYCLES)) u_timer (
    .clk(clk), .clr_n(por_ok_i), .run(timer_run), .done(timer_done)
  );

  always_ff @(posedge clk or negedge por_ok_i) begin
    if (!por_ok_i) begin
      state_q   <= SEQ_HOLD;
      cold_q    <= 1'b1;
      class_q   <= CLASS_POR;
      por_stb_q <= 1'b0;
      bor_stb_q <= 1'b0;
    end else begin
      por_stb_q <= release_evt & cold_q;
      bor_stb_q <= release_evt & !cold_q;
      if (release_evt) begin
        state_q <= SEQ_RUN;
        cold_q  <= 1'b0;
      end else if (bor_entry_evt) begin
        state_q <= SEQ_HOLD;
        class_q <= CLASS_BOR;
      end
    end
  end

  assign core_rst_n_o = (state_q == SEQ_RUN) & supply_ok;
  assign thr_write    = thr_we_i & core_rst_n_o;

  keep_reg #(.W(THR_W)) u_thr (
    .clk(clk), .clr_n(por_ok_i), .we(thr_write), .wd(thr_wd_i), .q(thr_o)
  );

  assign load_vec_o   = por_stb_q | bor_stb_q;
  assign init_por_o   = por_stb_q;
  assign init_bor_o   = bor_stb_q;
  assign init_class_o = class_q;
  assign pc_vec_o     = RESET_VEC;
endmodule

// File: rtl/supply_rst_chk.sv
module supply_rst_chk #(
  parameter int unsigned THR_W = 2
) (
  input logic             clk,
  input logic             por_ok_i,
  input logic             supply_ok,
  input logic             core_rst_n_o,
  input logic             load_vec_o,
  input logic             init_por_o,
  input logic             init_bor_o,
  input logic [THR_W-1:0] thr_o
);
  AST_HELD_LOW: assert property (@(posedge clk) disable iff (!por_ok_i)
    !supply_ok |-> !core_rst_n_o);                                  // R1
  AST_VEC_ON_RISE: assert property (@(posedge clk) disable iff (!por_ok_i)
    $rose(core_rst_n_o) |-> load_vec_o);                            // R4
  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!por_ok_i)
    load_vec_o |=> !load_vec_o);                                    // R4
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!por_ok_i)
    $onehot0({init_por_o, init_bor_o}));                            // R5
  AST_STROBE_WITH_LOAD: assert property (@(posedge clk) disable iff (!por_ok_i)
    load_vec_o |-> (init_por_o || init_bor_o));                     // R5
  AST_THR_FROZEN: assert property (@(posedge clk) disable iff (!por_ok_i)
    !core_rst_n_o |=> $stable(thr_o));                              // R7
endmodule

bind supply_rst_seq supply_rst_chk #(.THR_W(THR_W)) u_chk (
  .clk(clk),
  .por_ok_i(por_ok_i),
  .supply_ok(supply_ok),
  .core_rst_n_o(core_rst_n_o),
  .load_vec_o(load_vec_o),
  .init_por_o(init_por_o),
  .init_bor_o(init_bor_o),
  .thr_o(thr_o)
);

// File: tb/tb_supply_rst_seq.sv
`timescale 1ns/1ps
module tb_supply_rst_seq;
  localparam int D = 8;

  logic       clk = 1'b0;
  logic       por_ok_i = 1'b0, bor_ok_i = 1'b0, thr_we_i = 1'b0;
  logic [1:0] thr_wd_i = 2'b00;
  logic       core_rst_n_o, load_vec_o, init_por_o, init_bor_o;
  logic [15:0] pc_vec_o;
  logic [1:0] init_class_o, thr_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  supply_rst_seq #(.DELAY_CYCLES(D)) dut (
    .clk(clk), .por_ok_i(por_ok_i), .bor_ok_i(bor_ok_i),
    .thr_we_i(thr_we_i), .thr_wd_i(thr_wd_i),
    .core_rst_n_o(core_rst_n_o), .load_vec_o(load_vec_o), .pc_vec_o(pc_vec_o),
    .init_por_o(init_por_o), .init_bor_o(init_bor_o),
    .init_class_o(init_class_o), .thr_o(thr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts rising edges until the core is released; captures outputs there
  int rel_n; logic rel_lv, rel_ps, rel_bs; logic [15:0] rel_pc;
  task automatic wait_release();
    rel_n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); @(negedge clk);
      rel_n++;
      if (core_rst_n_o) break;
    end
    rel_lv = load_vec_o; rel_ps = init_por_o; rel_bs = init_bor_o; rel_pc = pc_vec_o;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1", "reset level", core_rst_n_o, 0);
    chk("R7", "thr default", thr_o, 0);
    chk("R6", "class at power-on", init_class_o, 1);
    chk("R4", "no load in reset", load_vec_o, 0);
    chk("R4", "vector", pc_vec_o, 16'h8000);

    // R2 cold power-up, both flags together
    por_ok_i = 1'b1; bor_ok_i = 1'b1;
    wait_release();
    chk("R2", "cold release edges", rel_n, D + 2);
    chk("R4", "load at release", rel_lv, 1);
    chk("R4", "vector at release", rel_pc, 16'h8000);
    chk("R5", "por strobe", rel_ps, 1);
    chk("R5", "bor strobe", rel_bs, 0);
    step(1);
    chk("R4", "load one cycle", load_vec_o, 0);
    chk("R5", "por strobe one cycle", init_por_o, 0);

    // R7 write while running
    thr_we_i = 1'b1; thr_wd_i = 2'b11;
    step(1);
    thr_we_i = 1'b0;
    chk("R7", "write while running", thr_o, 3);

    // R3/R8 brownout dips of several lengths
    for (int len = 0; len < 5; len++) begin
      bor_ok_i = 1'b0;
      step(1);
      chk("R1", "still high one edge after drop", core_rst_n_o, 1);
      step(1);
      chk("R1", "low two edges after drop", core_rst_n_o, 0);
      thr_we_i = 1'b1; thr_wd_i = 2'(len);
      step(len + 1);
      chk("R7", "write ignored in reset", thr_o, 3);
      thr_we_i = 1'b0;
      chk("R6", "class after brownout", init_class_o, 2);
      bor_ok_i = 1'b1;
      wait_release();
      chk("R3", "brownout release edges", rel_n, 3);
      chk("R5", "bor strobe", rel_bs, 1);
      chk("R5", "no por strobe", rel_ps, 0);
      chk("R4", "load at brownout release", rel_lv, 1);
      chk("R8", "thr kept", thr_o, 3);
      step(1);
      chk("R5", "bor strobe one cycle", init_bor_o, 0);
    end

    // R8/R10 power-on drop
    por_ok_i = 1'b0;
    #1;
    chk("R1", "async drop", core_rst_n_o, 0);
    chk("R8", "thr cleared", thr_o, 0);
    chk("R6", "class back to por", init_class_o, 1);
    step(10);
    chk("R10", "bor alone holds reset", core_rst_n_o, 0);

    // R2 staggered rise: bor rises k cycles after por
    for (int k = 0; k < 5; k++) begin
      por_ok_i = 1'b0; bor_ok_i = 1'b0;
      step(2);
      por_ok_i = 1'b1;
      step(k);
      if (k > 0) chk("R10", "por alone holds reset", core_rst_n_o, 0);
      bor_ok_i = 1'b1;
      wait_release();
      chk("R2", "staggered release edges", rel_n, D + 2);
      chk("R5", "por strobe staggered", rel_ps, 1);
    end

    // R9 power-on dip in mid count
    por_ok_i = 1'b0; step(2);
    por_ok_i = 1'b1;
    step(5);
    chk("R9", "held during count", core_rst_n_o, 0);
    por_ok_i = 1'b0; step(1);
    por_ok_i = 1'b1;
    wait_release();
    chk("R9", "restart after por dip", rel_n, D + 2);

    // R9 brownout dip in mid count
    por_ok_i = 1'b0; step(2);
    por_ok_i = 1'b1;
    step(6);
    bor_ok_i = 1'b0;
    step(4);
    chk("R9", "held during bor dip", core_rst_n_o, 0);
    bor_ok_i = 1'b1;
    wait_release();
    chk("R9", "restart after bor dip", rel_n, D + 2);
    chk("R9", "still power-on class", rel_ps, 1);
    chk("R9", "no bor strobe", rel_bs, 0);

    step(2);
    finish_run();
  end
endmodule